// File: doc/BRIEF.md
# Paged Flash Write and Erase Sequencer

This block runs on top of a serial flash command engine. It accepts a request made of a kind (program, 4 KB sector erase, 64 KB block erase, whole-device erase), a start address, a byte count and an opcode-set selector. It then issues a series of single commands to the command engine below it. A program of any length is split into chunks, and no chunk crosses a 256-byte page. Every chunk and every erase is preceded by a write-enable command and followed by status reads that repeat until the device reports idle. The caller's byte stream goes directly to the command engine, which takes `cmd_nbytes` data bytes for each program command.

The command engine takes the presented command while `cmd_valid` is high. It answers with a one-cycle `cmd_done` pulse, carrying on `cmd_status` the byte it read for a status command. The cycle after a `cmd_done`, the block presents its next command. The block finishes each request with a one-cycle `done`. If the number of busy status readings reaches `poll_limit`, it raises `err` in the same cycle as `done`.

Top module: `flash_pe_engine`

## Requirements
- R1: A program request is split into chunks. The first chunk has length min(remaining, 256 - (address mod 256)). Each later chunk starts on a 256-byte page boundary. Each chunk appears as one program command, with `cmd_nbytes` equal to its length and `cmd_addr` equal to its start address.
- R2: Every program and erase command is directly preceded by a completed write-enable command (0x06 in single-line mode, 0x06F9 in octal mode).
- R3: After each program or erase command, the block issues the read-status command (0x05 single-line, 0x05FA octal) again and again, as long as bit 0 of `cmd_status` is 1. Other status bits are ignored. Only a reading with bit 0 clear lets the block move on to the next chunk or to `done`.
- R4: When `req_octal`=0, the block uses these opcodes in the low byte of `cmd_opcode`, with the upper byte zero: program 0x12, sector erase 0x21, block erase 0xDC, device erase 0x60. `cmd_wide` is 0.
- R5: When `req_octal`=1, the block uses these 16-bit opcodes: program 0x12ED, sector erase 0x21DE, block erase 0xDC23, device erase 0x609F. `cmd_wide` is 1.
- R6: `req_kind` encodes the request as 0 program, 1 sector erase, 2 block erase, 3 device erase. Sector and block erase send `cmd_has_addr`=1 with the request address. Device erase sends `cmd_has_addr`=0. Erases send `cmd_nbytes`=0 and ignore `req_len`.
- R7: A program request with `req_len`=0 raises `done` in the cycle after the request edge. It issues no command.
- R8: If the count of busy readings for one operation reaches `poll_limit` (a limit of 0 acts as 1), the block raises `done` and `err` together and goes idle without issuing more commands.
- R9: `done` is a one-cycle pulse with no command presented. While `busy`=1, `req_valid` is ignored.
- R10: After reset, `busy`, `done`, `err` and `cmd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_kind | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 device erase |
| req_addr | input | 32 | Start address |
| req_len | input | 16 | Program byte count |
| req_octal | input | 1 | 1 selects the octal opcode set |
| poll_limit | input | 16 | Busy readings allowed per operation |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished pulse |
| err | output | 1 | Poll limit reached, with done |
| cmd_valid | output | 1 | Command presented to the command engine |
| cmd_opcode | output | 16 | Opcode of the presented command |
| cmd_wide | output | 1 | Opcode is two bytes |
| cmd_has_addr | output | 1 | Command carries an address phase |
| cmd_addr | output | 32 | Address of the command |
| cmd_nbytes | output | 9 | Data bytes the command writes |
| cmd_done | input | 1 | Presented command finished |
| cmd_status | input | 8 | Status byte returned with cmd_done |

## Verification
The assertions assume that `cmd_done` only ever arrives while a command is presented. They also assume that the command engine treats the cycle after each `cmd_done` as a fresh command. The page-bound and write-enable properties depend on this. The bench's command-engine model only counts latency while `cmd_valid` is high, and it pulses `cmd_done` for exactly one cycle. It also sends status bytes with bit 1 set, so that only bit 0 can decide the polling. Requests are only driven at falling edges, and they cover several lengths, unaligned starts and both opcode sets.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  typedef enum logic [1:0] {
    KIND_PROG  = 2'd0,
    KIND_SECT  = 2'd1,
    KIND_BLOCK = 2'd2,
    KIND_CHIP  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    SEL_WREN, SEL_RDSR, SEL_PROG, SEL_SECT, SEL_BLOCK, SEL_CHIP
  } sel_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_WREN, ST_OP, ST_POLL
  } st_e;
endpackage

// File: rtl/flash_pe_chunker.sv
module flash_pe_chunker #(
  parameter int PAGE_BYTES = 256,
  parameter int LEN_W      = 16,
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int CNT_W     = PAGE_W + 1
) (
  input  logic [PAGE_W-1:0] page_off,
  input  logic [LEN_W-1:0]  remaining,
  output logic [CNT_W-1:0]  chunk
);
  logic [CNT_W-1:0] room;
  logic             fits;

  always_comb begin
    room  = CNT_W'(PAGE_BYTES) - {1'b0, page_off};
    fits  = remaining < {{(LEN_W-CNT_W){1'b0}}, room};
    chunk = fits ? remaining[CNT_W-1:0] : room;
  end
endmodule

// File: rtl/flash_pe_opcode.sv
module flash_pe_opcode
  import flash_pe_pkg::*;
(
  input  sel_e        sel,
  input  logic        octal,
  output logic [15:0] opcode
);
  logic [7:0] base;

  always_comb begin
    case (sel)
      SEL_WREN:  base = 8'h06;
      SEL_RDSR:  base = 8'h05;
      SEL_PROG:  base = 8'h12;
      SEL_SECT:  base = 8'h21;
      SEL_BLOCK: base = 8'hDC;
      SEL_CHIP:  base = 8'h60;
      default:   base = 8'h00;
    endcase
    // octal set repeats the opcode inverted in the second byte
    opcode = octal ? {base, ~base} : {8'h00, base};
  end
endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
  import flash_pe_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int POLL_W     = 16,
  parameter int PAGE_BYTES = 256,
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int CNT_W     = PAGE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_octal,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cmd_valid,
  output logic [15:0]       cmd_opcode,
  output logic              cmd_wide,
  output logic              cmd_has_addr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CNT_W-1:0]  cmd_nbytes,
  input  logic              cmd_done,
  input  logic [7:0]        cmd_status
);
  st_e               st_q, st_n;
  kind_e             kind_q, kind_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [LEN_W-1:0]  rem_q, rem_n;
  logic [POLL_W-1:0] poll_q, poll_n, poll_inc;
  logic              oct_q, oct_n;
  logic              done_q, done_n, err_q, err_n;
  logic              dp_en;
  logic [CNT_W-1:0]  chunk;
  logic [LEN_W-1:0]  chunk_len;
  sel_e              sel;

  flash_pe_chunker #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) u_chunk (
    .page_off (addr_q[PAGE_W-1:0]),
    .remaining(rem_q),
    .chunk    (chunk)
  );

  flash_pe_opcode u_opc (
    .sel   (sel),
    .octal (oct_q),
    .opcode(cmd_opcode)
  );

  assign chunk_len = {{(LEN_W-CNT_W){1'b0}}, chunk};
  assign poll_inc  = poll_q + 1'b1;
  assign dp_en     = (st_q == ST_IDLE) ? req_valid : cmd_done;

  always_comb begin
    st_n   = st_q;
    kind_n = kind_q;
    addr_n = addr_q;
    rem_n  = rem_q;
    oct_n  = oct_q;
    poll_n = poll_q;
    done_n = 1'b0;
    err_n  = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        kind_n = kind_e'(req_kind);
        addr_n = req_addr;
        rem_n  = req_len;
        oct_n  = req_octal;
        if (kind_e'(req_kind) == KIND_PROG && req_len == '0) done_n = 1'b1;
        else                                                 st_n   = ST_WREN;
      end
      ST_WREN: if (cmd_done) st_n = ST_OP;
      ST_OP: if (cmd_done) begin
        st_n   = ST_POLL;
        poll_n = '0;
      end
      ST_POLL: if (cmd_done) begin
        if (cmd_status[0]) begin
          if (poll_inc >= poll_limit) begin
            done_n = 1'b1;
            err_n  = 1'b1;
            st_n   = ST_IDLE;
          end else begin
            poll_n = poll_inc;
          end
        end else if (kind_q == KIND_PROG && rem_q != chunk_len) begin
          addr_n = addr_q + {{(ADDR_W-CNT_W){1'b0}}, chunk};
          rem_n  = rem_q - chunk_len;
          st_n   = ST_WREN;
        end else begin
          done_n = 1'b1;
          st_n   = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      kind_q <= KIND_PROG;
      addr_q <= '0;
      rem_q  <= '0;
      oct_q  <= 1'b0;
      poll_q <= '0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      err_q  <= err_n;
      if (dp_en) begin
        kind_q <= kind_n;
        addr_q <= addr_n;
        rem_q  <= rem_n;
        oct_q  <= oct_n;
        poll_q <= poll_n;
      end
    end
  end

  always_comb begin
    case (st_q)
      ST_WREN: sel = SEL_WREN;
      ST_POLL: sel = SEL_RDSR;
      ST_OP: case (kind_q)
        KIND_PROG:  sel = SEL_PROG;
        KIND_SECT:  sel = SEL_SECT;
        KIND_BLOCK: sel = SEL_BLOCK;
        default:    sel = SEL_CHIP;
      endcase
      default: sel = SEL_WREN;
    endcase
  end

  assign busy         = (st_q != ST_IDLE);
  assign cmd_valid    = busy;
  assign cmd_wide     = busy & oct_q;
  assign cmd_has_addr = (st_q == ST_OP) && (kind_q != KIND_CHIP);
  assign cmd_addr     = cmd_has_addr ? addr_q : '0;
  assign cmd_nbytes   = (st_q == ST_OP && kind_q == KIND_PROG) ? chunk : '0;
  assign done         = done_q;
  assign err          = err_q;

  // record whether the last completed command was a write enable
  logic wren_last;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     wren_last <= 1'b0;
    else if (cmd_valid && cmd_done) wren_last <= (sel == SEL_WREN);
  end

  AST_PAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_nbytes != '0) |->
      (({1'b0, cmd_addr[PAGE_W-1:0]} + cmd_nbytes) <= CNT_W'(PAGE_BYTES))); // R1
  AST_WREN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && sel != SEL_WREN && sel != SEL_RDSR) |-> wren_last); // R2
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_valid && !cmd_has_addr)); // R10
endmodule

// File: tb/flash_pe_engine_bench.sv
module flash_pe_engine_bench;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [31:0] req_addr;
  logic [15:0] req_len;
  logic        req_octal;
  logic [15:0] poll_limit;
  logic        busy, done, err, cmd_valid, cmd_wide, cmd_has_addr;
  logic [15:0] cmd_opcode;
  logic [31:0] cmd_addr;
  logic [8:0]  cmd_nbytes;
  logic        cmd_done;
  logic [7:0]  cmd_status;

  always #4 clk = ~clk;

  flash_pe_engine u_flash_pe_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_len(req_len), .req_octal(req_octal),
    .poll_limit(poll_limit), .busy(busy), .done(done), .err(err),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_wide(cmd_wide),
    .cmd_has_addr(cmd_has_addr), .cmd_addr(cmd_addr), .cmd_nbytes(cmd_nbytes),
    .cmd_done(cmd_done), .cmd_status(cmd_status)
  );

  int checks = 0;
  int fails  = 0;

  // command engine model and command log
  int          lat_cnt;
  int          busy_cfg;
  int          busy_left;
  int          n_log;
  logic [15:0] log_op   [64];
  logic [31:0] log_addr [64];
  logic [8:0]  log_nb   [64];
  logic        log_has  [64];
  logic        log_wide [64];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_done   <= 1'b0;
      cmd_status <= 8'h00;
      lat_cnt    <= 0;
      busy_left  <= 0;
    end else if (cmd_done) begin
      cmd_done <= 1'b0;
      lat_cnt  <= 0;
    end else if (cmd_valid) begin
      if (lat_cnt == LAT - 1) begin
        cmd_done <= 1'b1;
        if (n_log < 64) begin
          log_op[n_log]   <= cmd_opcode;
          log_addr[n_log] <= cmd_addr;
          log_nb[n_log]   <= cmd_nbytes;
          log_has[n_log]  <= cmd_has_addr;
          log_wide[n_log] <= cmd_wide;
        end
        n_log <= n_log + 1;
        if (cmd_opcode == 16'h0005 || cmd_opcode == 16'h05FA) begin
          cmd_status <= (busy_left != 0) ? 8'h03 : 8'h02;
          if (busy_left != 0) busy_left <= busy_left - 1;
        end else begin
          busy_left  <= busy_cfg;
          cmd_status <= 8'h02;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  // expected command list
  int          n_exp;
  logic [15:0] exp_op   [64];
  logic [31:0] exp_addr [64];
  logic [8:0]  exp_nb   [64];
  logic        exp_has  [64];

  function automatic logic [15:0] code(int op, bit oct);
    case (op)
      0: code = oct ? 16'h06F9 : 16'h0006;
      1: code = oct ? 16'h05FA : 16'h0005;
      2: code = oct ? 16'h12ED : 16'h0012;
      3: code = oct ? 16'h21DE : 16'h0021;
      4: code = oct ? 16'hDC23 : 16'h00DC;
      default: code = oct ? 16'h609F : 16'h0060;
    endcase
  endfunction

  task automatic push(logic [15:0] op, logic [31:0] a, logic [8:0] nb, logic has);
    exp_op[n_exp] = op; exp_addr[n_exp] = a; exp_nb[n_exp] = nb; exp_has[n_exp] = has;
    n_exp++;
  endtask

  task automatic push_op_poll(logic [15:0] op, logic [31:0] a, logic [8:0] nb,
                              logic has, bit oct, int bn);
    push(code(0, oct), 32'h0, 9'd0, 1'b0);
    push(op, a, nb, has);
    for (int k = 0; k <= bn; k++) push(code(1, oct), 32'h0, 9'd0, 1'b0);
  endtask

  task automatic build_exp(logic [1:0] kind, logic [31:0] a, int len, bit oct, int bn);
    int room, c;
    n_exp = 0;
    if (kind == 2'd0) begin
      while (len > 0) begin
        room = 256 - int'(a[7:0]);
        c = (len < room) ? len : room;
        push_op_poll(code(2, oct), a, 9'(c), 1'b1, oct, bn);
        a = a + 32'(c);
        len = len - c;
      end
    end else if (kind == 2'd3) begin
      push_op_poll(code(5, oct), 32'h0, 9'd0, 1'b0, oct, bn);
    end else begin
      push_op_poll(code(kind == 2'd1 ? 3 : 4, oct), a, 9'd0, 1'b1, oct, bn);
    end
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  int got_wait;
  logic got_err;

  task automatic run_req(logic [1:0] kind, logic [31:0] a, logic [15:0] len, logic oct);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = a; req_len = len; req_octal = oct;
    @(negedge clk);
    req_valid = 1'b0;
    got_wait = 0;
    while (!done && got_wait < 5000) begin
      @(negedge clk);
      got_wait++;
    end
    got_err = err;
    if (got_wait >= 5000) check(1'b0, "R9", "request never finished", got_wait, 0);
  endtask

  task automatic compare_log(string req);
    check(n_log == n_exp, req, "command count", n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      check(log_op[i] == exp_op[i] && log_addr[i] == exp_addr[i] &&
            log_nb[i] == exp_nb[i] && log_has[i] == exp_has[i] &&
            log_wide[i] == (exp_op[i][15:8] != 8'h00),
            req, $sformatf("command %0d op/addr/len", i),
            {log_op[i], log_addr[i]}, {exp_op[i], exp_addr[i]});
    end
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [15:0] len;
    logic        oct;
    logic [3:0]  bn;
  } vec_t;

  localparam vec_t VEC [0:6] = '{
    '{2'd0, 32'h0000_0100, 16'd16,  1'b0, 4'd1},  // R1 R4 single chunk
    '{2'd0, 32'h0000_01F0, 16'd40,  1'b0, 4'd0},  // R1 crosses one page
    '{2'd0, 32'h0000_0080, 16'd600, 1'b1, 4'd2},  // R1 R5 three chunks
    '{2'd1, 32'h0000_3000, 16'd77,  1'b0, 4'd3},  // R3 R6 sector
    '{2'd2, 32'h0002_0000, 16'd0,   1'b1, 4'd1},  // R5 R6 block
    '{2'd3, 32'h1234_5678, 16'd9,   1'b0, 4'd2},  // R6 device erase
    '{2'd0, 32'h0000_0000, 16'd256, 1'b1, 4'd0}   // R1 full page
  };

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_addr = '0; req_len = '0;
    req_octal = 1'b0; poll_limit = 16'd100; busy_cfg = 0; n_log = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !err, "R10", "status outputs after reset", {busy, done, err}, 0);
    check(!cmd_valid, "R10", "cmd_valid after reset", cmd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !cmd_valid, "R10", "idle after release", {busy, cmd_valid}, 0);

    for (int v = 0; v < 7; v++) begin
      n_log = 0;
      busy_cfg = int'(VEC[v].bn);
      build_exp(VEC[v].kind, VEC[v].addr, int'(VEC[v].len), VEC[v].oct, int'(VEC[v].bn));
      run_req(VEC[v].kind, VEC[v].addr, VEC[v].len, VEC[v].oct);
      check(!got_err, "R3", "err on good run", got_err, 0);
      compare_log("R1/R2/R4/R5/R6");
      @(negedge clk);
      check(!done, "R9", "done lasts one cycle", done, 0);
    end

    // R7 zero-length program
    n_log = 0;
    run_req(2'd0, 32'h0000_0040, 16'd0, 1'b0);
    check(got_wait == 0, "R7", "done cycle after request", got_wait, 0);
    check(n_log == 0, "R7", "no commands", n_log, 0);

    // R8 poll limit
    n_log = 0; busy_cfg = 10; poll_limit = 16'd3;
    run_req(2'd1, 32'h0000_5000, 16'd0, 1'b0);
    check(got_err == 1'b1, "R8", "err with done", got_err, 1);
    check(n_log == 5, "R8", "commands before giving up", n_log, 5);
    repeat (10) @(negedge clk);
    check(n_log == 5 && !busy, "R8", "no commands after err", n_log, 5);
    poll_limit = 16'd100;

    // R9 request while busy is ignored
    n_log = 0; busy_cfg = 0;
    build_exp(2'd1, 32'h0000_7000, 0, 1'b1, 0);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd1; req_addr = 32'h0000_7000; req_len = 16'd0; req_octal = 1'b1;
    @(negedge clk);
    req_kind = 2'd3; req_octal = 1'b0;   // still high while busy
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    got_wait = 0;
    while (!done && got_wait < 5000) begin
      @(negedge clk);
      got_wait++;
    end
    compare_log("R9");
    repeat (5) @(negedge clk);
    check(!busy && n_log == n_exp, "R9", "no second request started", n_log, n_exp);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule